// File: doc/BRIEF.md
# Byte-Wide Nonvolatile RAM Emulator with Identification Bank

This block is a clocked, synthesizable stand-in for a byte-wide nonvolatile RAM with an asynchronous SRAM-style pin interface. A processor-side bus model drives the pins directly and without any timing relation to the system clock. The block holds 8192 bytes addressed by 13 address bits. A separate input/output data pair plus an output-enable flag replaces the bidirectional bus. Two chip enables of opposite polarity must both be true for the device to respond. A write is framed by the overlap of that selection with a low write enable, and it takes effect when the overlap closes.

A mode flag stands for the raised voltage on one address pin and redirects accesses to a 64-byte identification bank. Its index is taken from six scattered address bits. The two lowest slots return fixed identification codes, and the other 62 slots are ordinary user storage. A write-inhibit input from a supply monitor freezes the interface. Every control and address pin is brought into the clock domain through a two-stage synchronizer. After reset, an internal sweep fills the main array with ones before the block answers.

Top module: `nvram_emu`

## Requirements
- R1: The main array holds 8192 bytes, one per 13-bit address. A read returns the byte most recently written to that address.
- R2: The device is selected only when `sel_n`=0 and `sel_p`=1. Under any other enable combination, `dout_en` stays 0 and write attempts leave memory unchanged.
- R3: While the device is selected, `wr_n`=0 performs a write whatever `oe_n` is. With `wr_n`=1 and `oe_n`=0 the byte is driven with `dout_en`=1. With both high, `dout_en`=0. Whenever `dout_en`=0, `dout` reads 00h.
- R4: A write lasts while selection and a low `wr_n` overlap. It may be ended by `wr_n` rising or by either enable going inactive. The address, mode and data present in the last synchronized cycle of the overlap are stored.
- R5: If `dout_en` is 1 during a read and `wr_n` falls, `dout_en` returns to 0 three clock edges later.
- R6: After reset, `dout_en` is 0. For 1024 cycles while the array is filled, reads do not drive and writes are dropped. After that, every main-array byte reads FFh.
- R7: With `id_mode`=1, the access goes to the identification bank and not to the main array. The 6-bit slot index is {addr[6], addr[5], addr[4], addr[12], addr[11], addr[10]}, most significant bit first.
- R8: Slot 0 reads 34h and slot 1 reads 41h. Writes to those two slots are dropped.
- R9: Slots 2 to 63 read FFh after reset and are readable and writable like the main array.
- R10: While `wr_inhibit`=1, `dout_en` stays 0 and no write is stored.
- R11: A pin change reaches `dout_en` on the third rising clock edge after it is applied.
- R12: A write whose overlap is still open when `wr_inhibit` rises is discarded, even after the inhibit is later released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Chip enable, active low |
| sel_p | input | 1 | Chip enable, active high |
| wr_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| id_mode | input | 1 | Selects the identification bank instead of the main array |
| wr_inhibit | input | 1 | Supply-monitor lockout, active high |
| addr | input | 13 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 00h when not driving |
| dout_en | output | 1 | High when the data bus would be driven |

## Verification
The hardest case to reach is a write whose overlap is open at the moment the inhibit rises. To get there, the bench holds select and a low write enable for several cycles, raises the inhibit, and releases write enable only while the inhibit is still high. It then drops the inhibit and reads the address back. A second hard case is a write closed by an enable rather than by write enable. The bench also drives the scattered identification index with neighbouring single-bit indices, so that a swapped bit order shows up as a wrong readback.

// File: rtl/nvram_pkg.sv
package nvram_pkg;

    localparam int ADDR_W   = 13;
    localparam int DATA_W   = 8;
    localparam int ID_W     = 6;
    localparam int LANE_W   = 3;
    localparam int ID_SLOTS = 1 << ID_W;

    localparam logic [DATA_W-1:0] MFR_CODE = 8'h34;
    localparam logic [DATA_W-1:0] DEV_CODE = 8'h41;
    localparam logic [ID_W-1:0]   FIRST_USER_SLOT = 6'd2;

    // pin bundle carried through the synchronizer
    typedef struct packed {
        logic              sel_n;
        logic              sel_p;
        logic              wr_n;
        logic              oe_n;
        logic              id_mode;
        logic              inhibit;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] din;
    } pins_t;

    // write held open until the overlap closes
    typedef struct packed {
        logic              is_id;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wreq_t;

    localparam pins_t PIN_IDLE = '{sel_n: 1'b1, sel_p: 1'b0, wr_n: 1'b1, oe_n: 1'b1,
                                   id_mode: 1'b0, inhibit: 1'b1,
                                   addr: '0, din: '0};

    // scattered identification index, msb first
    function automatic logic [ID_W-1:0] id_index(input logic [ADDR_W-1:0] a);
        return {a[6], a[5], a[4], a[12], a[11], a[10]};
    endfunction

endpackage

// File: rtl/nvram_sync.sv
module nvram_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/nvram_ctrl.sv
module nvram_ctrl
    import nvram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins,
    input  logic  init_busy,
    output logic  rd_en,
    output logic  main_we,
    output logic  id_we,
    output wreq_t wreq
);
    logic active, overlap, wr_open, commit;

    assign active  = ~pins.inhibit & ~init_busy & ~pins.sel_n & pins.sel_p;
    assign overlap = active & ~pins.wr_n;
    assign rd_en   = active & pins.wr_n & ~pins.oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_open <= 1'b0;
            wreq    <= '0;
        end else begin
            wr_open <= overlap;
            if (overlap) wreq <= '{is_id: pins.id_mode, addr: pins.addr, data: pins.din};
        end
    end

    // overlap closed this cycle without a supply lockout
    assign commit  = wr_open & ~overlap & ~pins.inhibit;
    assign main_we = commit & ~wreq.is_id;
    assign id_we   = commit & wreq.is_id & (id_index(wreq.addr) >= FIRST_USER_SLOT);
endmodule

// File: rtl/nvram_main_array.sv
module nvram_main_array #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int LANE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              busy
);
    localparam int ROW_W    = ADDR_W - LANE_W;
    localparam int ROWS     = 1 << ROW_W;
    localparam int ROW_BITS = DATA_W << LANE_W;

    logic [ROW_BITS-1:0] rows [ROWS];
    logic [ROW_W:0]      sweep;

    assign busy = ~sweep[ROW_W];

    always_ff @(posedge clk) begin
        if (rst)       sweep <= '0;
        else if (busy) sweep <= sweep + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (busy)
            rows[sweep[ROW_W-1:0]] <= '1;
        else if (we)
            rows[waddr[ADDR_W-1:LANE_W]][int'(waddr[LANE_W-1:0])*DATA_W +: DATA_W] <= wdata;
    end

    assign rdata = rows[raddr[ADDR_W-1:LANE_W]][int'(raddr[LANE_W-1:0])*DATA_W +: DATA_W];
endmodule

// File: rtl/nvram_id_bank.sv
module nvram_id_bank
    import nvram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ID_W-1:0]   widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ID_W-1:0]   ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] slot [ID_SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ID_SLOTS; i++) slot[i] <= '1;
        end else if (we) begin
            slot[widx] <= wdata;
        end
    end

    always_comb begin
        unique case (ridx)
            6'd0:    rdata = MFR_CODE;
            6'd1:    rdata = DEV_CODE;
            default: rdata = slot[ridx];
        endcase
    end
endmodule

// File: rtl/nvram_emu.sv
module nvram_emu
    import nvram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              sel_p,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic              id_mode,
    input  logic              wr_inhibit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    pins_t             raw_pins, syn;
    wreq_t             wreq;
    logic              rd_en, main_we, id_we, init_busy;
    logic [DATA_W-1:0] main_rd, id_rd;

    assign raw_pins = '{sel_n: sel_n, sel_p: sel_p, wr_n: wr_n, oe_n: oe_n,
                        id_mode: id_mode, inhibit: wr_inhibit, addr: addr, din: din};

    nvram_sync #(.W($bits(pins_t)), .STAGES(2), .RST_VAL(PIN_IDLE)) u_sync (
        .clk(clk), .rst(rst), .d(raw_pins), .q(syn)
    );

    nvram_ctrl u_ctrl (
        .clk(clk), .rst(rst), .pins(syn), .init_busy(init_busy),
        .rd_en(rd_en), .main_we(main_we), .id_we(id_we), .wreq(wreq)
    );

    nvram_main_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_main (
        .clk(clk), .rst(rst), .we(main_we), .waddr(wreq.addr), .wdata(wreq.data),
        .raddr(syn.addr), .rdata(main_rd), .busy(init_busy)
    );

    nvram_id_bank u_id (
        .clk(clk), .rst(rst), .we(id_we), .widx(id_index(wreq.addr)), .wdata(wreq.data),
        .ridx(id_index(syn.addr)), .rdata(id_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_en <= 1'b0;
            dout    <= '0;
        end else begin
            dout_en <= rd_en;
            dout    <= rd_en ? (syn.id_mode ? id_rd : main_rd) : '0;
        end
    end
endmodule

// File: rtl/nvram_chk.sv
module nvram_chk (
    input logic clk,
    input logic rst,
    input logic sel_n,
    input logic sel_p,
    input logic wr_n,
    input logic oe_n,
    input logic wr_inhibit,
    input logic dout_en,
    input logic main_we,
    input logic id_we,
    input logic init_busy
);
    logic [1:0] age;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end
    assign warm = (age == 2'd3);

    assert_select_R2: assert property (@(posedge clk) disable iff (rst)
        (warm && dout_en) |-> (!$past(sel_n, 3) && $past(sel_p, 3)));

    assert_read_mode_R3: assert property (@(posedge clk) disable iff (rst)
        (warm && dout_en) |-> ($past(wr_n, 3) && !$past(oe_n, 3)));

    assert_inhibit_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (warm && dout_en) |-> !$past(wr_inhibit, 3));

    assert_one_target_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({main_we, id_we}));

    assert_no_write_in_fill_R6: assert property (@(posedge clk) disable iff (rst)
        init_busy |-> !(main_we || id_we));
endmodule

bind nvram_emu nvram_chk u_chk (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sel_p(sel_p), .wr_n(wr_n), .oe_n(oe_n),
    .wr_inhibit(wr_inhibit), .dout_en(dout_en), .main_we(main_we), .id_we(id_we),
    .init_busy(init_busy)
);

// File: tb/test_nvram_emu.sv
`timescale 1ns/1ps
module test_nvram_emu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1, sel_p = 1'b0, wr_n = 1'b1, oe_n = 1'b1;
    logic        id_mode = 1'b0, wr_inhibit = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0] main_model [int];
    logic [7:0] id_model [int];

    always #2.5 clk = ~clk;

    nvram_emu i_nvram_emu (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sel_p(sel_p), .wr_n(wr_n), .oe_n(oe_n),
        .id_mode(id_mode), .wr_inhibit(wr_inhibit), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
        finish_run();
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_idle();
        sel_n = 1'b1; sel_p = 1'b0; wr_n = 1'b1; oe_n = 1'b1;
    endtask

    function automatic logic [12:0] id_addr(input logic [5:0] idx, input logic [12:0] fill);
        logic [12:0] a = fill;
        a[6] = idx[5]; a[5] = idx[4]; a[4] = idx[3];
        a[12] = idx[2]; a[11] = idx[1]; a[10] = idx[0];
        return a;
    endfunction

    function automatic logic [5:0] idx_of(input logic [12:0] a);
        return {a[6], a[5], a[4], a[12], a[11], a[10]};
    endfunction

    function automatic logic [7:0] exp_byte(input logic idm, input logic [12:0] a);
        int k;
        if (idm) begin
            k = int'(idx_of(a));
            if (k == 0) return 8'h34;
            if (k == 1) return 8'h41;
            return id_model.exists(k) ? id_model[k] : 8'hFF;
        end
        k = int'(a);
        return main_model.exists(k) ? main_model[k] : 8'hFF;
    endfunction

    function automatic void note_write(input logic idm, input logic [12:0] a, input logic [7:0] d);
        if (idm) begin
            if (idx_of(a) >= 6'd2) id_model[int'(idx_of(a))] = d;
        end else begin
            main_model[int'(a)] = d;
        end
    endfunction

    // style 0: ended by wr_n, 1: ended by sel_p, 2: oe_n low throughout, 3: ended by sel_n
    task automatic do_write(input logic idm, input logic [12:0] a, input logic [7:0] d, input int style);
        addr = a; din = d; id_mode = idm;
        sel_n = 1'b0; sel_p = 1'b1;
        if (style == 2) oe_n = 1'b0;
        step(1);
        wr_n = 1'b0;
        step(3);
        if (style == 1)      sel_p = 1'b0;
        else if (style == 3) sel_n = 1'b1;
        else                 wr_n  = 1'b1;
        step(1);
        go_idle();
        step(4);
        note_write(idm, a, d);
    endtask

    task automatic do_read(input logic idm, input logic [12:0] a, output logic en, output logic [7:0] d);
        addr = a; id_mode = idm;
        sel_n = 1'b0; sel_p = 1'b1; wr_n = 1'b1; oe_n = 1'b0;
        step(4);
        en = dout_en; d = dout;
        go_idle();
        step(4);
    endtask

    task automatic read_check(input logic idm, input logic [12:0] a, input string req);
        logic en; logic [7:0] d; logic [7:0] e;
        e = exp_byte(idm, a);
        do_read(idm, a, en, d);
        check(en == 1'b1, req, en, 1);
        check(d == e, req, d, e);
    endtask

    initial begin
        logic en; logic [7:0] d;
        logic [12:0] hot [4];
        void'($urandom(32'd5813));
        step(4);
        // R6 reset state
        check(dout_en == 1'b0, "R6 reset dout_en", dout_en, 0);
        rst = 1'b0;
        step(2);
        // R6 fill phase: reads do not drive, writes dropped
        sel_n = 1'b0; sel_p = 1'b1; oe_n = 1'b0; addr = 13'h0100;
        step(5);
        check(dout_en == 1'b0, "R6 fill read quiet", dout_en, 0);
        go_idle(); step(2);
        addr = 13'h0100; din = 8'h5A; sel_n = 1'b0; sel_p = 1'b1; step(1);
        wr_n = 1'b0; step(3); wr_n = 1'b1; step(1); go_idle();
        step(1100);
        read_check(1'b0, 13'h0100, "R6 fill write dropped");
        read_check(1'b0, 13'h1FFF, "R6 ones after fill");
        read_check(1'b0, 13'h0000, "R6 ones after fill");

        // R11 latency of dout_en
        addr = 13'h0003; id_mode = 1'b0;
        sel_n = 1'b0; sel_p = 1'b1; wr_n = 1'b1; oe_n = 1'b0;
        step(2);
        check(dout_en == 1'b0, "R11 not before third edge", dout_en, 0);
        step(1);
        check(dout_en == 1'b1, "R11 on third edge", dout_en, 1);
        // R5 write enable falling releases outputs
        din = 8'hC3; wr_n = 1'b0;
        step(2);
        check(dout_en == 1'b1, "R5 still driving two edges after", dout_en, 1);
        step(1);
        check(dout_en == 1'b0, "R5 released", dout_en, 0);
        wr_n = 1'b1; step(1); go_idle(); step(4);
        note_write(1'b0, 13'h0003, 8'hC3);
        read_check(1'b0, 13'h0003, "R3 write with oe low");

        // R4 write framing styles, R1 readback
        do_write(1'b0, 13'h0A55, 8'h11, 0);
        do_write(1'b0, 13'h0A56, 8'h22, 1);
        do_write(1'b0, 13'h0A57, 8'h33, 2);
        do_write(1'b0, 13'h0A58, 8'h44, 3);
        read_check(1'b0, 13'h0A55, "R4 ended by wr_n");
        read_check(1'b0, 13'h0A56, "R4 ended by sel_p");
        read_check(1'b0, 13'h0A57, "R3 write with oe low");
        read_check(1'b0, 13'h0A58, "R4 ended by sel_n");
        // R4 last cycle of overlap wins
        addr = 13'h0777; din = 8'h01; id_mode = 1'b0; sel_n = 1'b0; sel_p = 1'b1; step(1);
        wr_n = 1'b0; step(3); din = 8'h9E; step(3); wr_n = 1'b1; step(1); go_idle(); step(4);
        note_write(1'b0, 13'h0777, 8'h9E);
        read_check(1'b0, 13'h0777, "R4 final data stored");

        // R2 deselect combinations
        for (int c = 0; c < 3; c++) begin
            logic [1:0] en_pat = (c == 0) ? 2'b10 : (c == 1) ? 2'b11 : 2'b00;
            addr = 13'h0A55; din = 8'hEE; id_mode = 1'b0;
            sel_n = en_pat[1]; sel_p = en_pat[0]; oe_n = 1'b0; wr_n = 1'b1;
            step(4);
            check(dout_en == 1'b0, "R2 deselected read quiet", dout_en, 0);
            check(dout == 8'h00, "R3 idle dout zero", dout, 0);
            wr_n = 1'b0; step(4); wr_n = 1'b1; step(1); go_idle(); step(4);
            read_check(1'b0, 13'h0A55, "R2 deselected write ignored");
        end
        // R3 both high: outputs off
        addr = 13'h0A55; sel_n = 1'b0; sel_p = 1'b1; wr_n = 1'b1; oe_n = 1'b1;
        step(4);
        check(dout_en == 1'b0, "R3 outputs off", dout_en, 0);
        check(dout == 8'h00, "R3 outputs off dout", dout, 0);
        go_idle(); step(2);

        // R7 R8 R9 identification bank
        read_check(1'b1, id_addr(6'd0, 13'h0000), "R8 slot 0 code");
        read_check(1'b1, id_addr(6'd1, 13'h0081), "R8 slot 1 code");
        read_check(1'b1, id_addr(6'd5, 13'h0000), "R9 user slot starts ones");
        do_write(1'b1, id_addr(6'd0, 13'h0000), 8'h00, 0);
        do_write(1'b1, id_addr(6'd1, 13'h0000), 8'h77, 1);
        read_check(1'b1, id_addr(6'd0, 13'h0000), "R8 slot 0 write dropped");
        read_check(1'b1, id_addr(6'd1, 13'h0000), "R8 slot 1 write dropped");
        do_write(1'b1, id_addr(6'd2, 13'h0000), 8'hA2, 0);
        do_write(1'b1, id_addr(6'd63, 13'h0000), 8'hA3, 0);
        for (int b = 0; b < 6; b++) begin
            logic [5:0] ix = 6'(1) << b;
            if (ix >= 6'd2) do_write(1'b1, id_addr(ix, 13'h0008), 8'hB0 + 8'(b), 2);
        end
        read_check(1'b1, id_addr(6'd2, 13'h0000), "R9 slot 2");
        read_check(1'b1, id_addr(6'd63, 13'h0000), "R9 slot 63");
        for (int b = 1; b < 6; b++)
            read_check(1'b1, id_addr(6'(1) << b, 13'h0000), "R7 index bit order");
        read_check(1'b0, id_addr(6'd2, 13'h0000), "R7 main array untouched");
        read_check(1'b0, id_addr(6'd63, 13'h0000), "R7 main array untouched");

        // R10 inhibit
        wr_inhibit = 1'b1;
        addr = 13'h0A56; id_mode = 1'b0; sel_n = 1'b0; sel_p = 1'b1; oe_n = 1'b0;
        step(5);
        check(dout_en == 1'b0, "R10 inhibit read quiet", dout_en, 0);
        din = 8'h5F; wr_n = 1'b0; step(4); wr_n = 1'b1; step(1); go_idle(); step(3);
        wr_inhibit = 1'b0; step(3);
        read_check(1'b0, 13'h0A56, "R10 inhibited write dropped");
        // R12 open write discarded by inhibit
        addr = 13'h0A57; din = 8'h6D; sel_n = 1'b0; sel_p = 1'b1; step(1);
        wr_n = 1'b0; step(4);
        wr_inhibit = 1'b1; step(4);
        wr_n = 1'b1; step(1); go_idle(); step(3);
        wr_inhibit = 1'b0; step(4);
        read_check(1'b0, 13'h0A57, "R12 open write discarded");

        // R1 random traffic against the model
        for (int h = 0; h < 4; h++) hot[h] = 13'($urandom);
        for (int n = 0; n < 400; n++) begin
            logic idm = ($urandom % 5) == 0;
            logic [12:0] a = (($urandom % 2) == 0) ? hot[$urandom % 4] : 13'($urandom);
            if (($urandom % 2) == 0)
                do_write(idm, a, 8'($urandom), int'($urandom % 4));
            else
                read_check(idm, a, idm ? "R9 random id traffic" : "R1 random traffic");
        end
        for (int h = 0; h < 4; h++) read_check(1'b0, hot[h], "R1 hot address final");

        finish_run();
    end
endmodule